// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block is the counting core of a real-time clock. Every time a one-second enable pulse arrives, it advances a chain of packed-BCD fields: seconds, minutes, hours, a day-of-week counter, day of month, month and a two-digit year. A carry out of each field steps the next one. The day-of-month limit follows the current month and a leap-year rule on the two-digit year. The month register also holds a century flag, which toggles when the year wraps from 99 to 00.

Hours are counted in either 24-hour or 12-hour form, chosen by a mode input. In 12-hour form the hour byte holds a BCD hour from 1 to 12 in its low five bits and a PM flag in bit 5. Midnight is 12 AM and noon is 12 PM. A host can write any register through a parallel load strobe with an address and a data byte. An oscillator-stop flag is raised by reset and freezes all counting until the host writes it clear.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hour 0x12, weekday 0x00, day 0x01, month 0x01 (century bit 7 clear), year 0x00, and the stop flag reads 1.
- R2: While the stop flag is 1, one-second pulses change no field. Loading address 7 with data bit 4 at 0 clears the flag and lets counting start. Loading it with bit 4 at 1 sets the flag.
- R3: Seconds and minutes count in BCD from 0x00 to 0x59. A pulse at 0x59 gives 0x00 and steps the next field.
- R4: With mode24 = 1, the hour counts BCD 0x00 to 0x23. A step from 0x23 gives 0x00 and advances the day.
- R5: With mode24 = 0, the hour sequence is 0x11 (11 AM) to 0x32 (12 PM) to 0x21 (1 PM), and 0x31 (11 PM) to 0x12 (12 AM) to 0x01. Bit 5 is PM and toggles only when the hour becomes 12. The 11 PM to 12 AM step advances the day.
- R6: The day wraps to 0x01 after 0x31 in months 1, 3, 5, 7, 8, 10 and 12. It wraps after 0x30 in months 4, 6, 9 and 11. In month 2 it wraps after 0x29 when the year is divisible by 4, and after 0x28 otherwise.
- R7: A day wrap in month 0x12 gives month 0x01 and advances the year. A year step from 0x99 gives 0x00 and toggles month bit 7 (century).
- R8: The weekday steps once with each day advance, counting 0 to 6 and wrapping to 0.
- R9: A load writes the data byte to the register picked by the address: 0 seconds, 1 minutes, 2 hour, 3 weekday, 4 day, 5 month (bit 7 century), 6 year, 7 stop flag in bit 4. A one-second pulse in the same cycle as a load is dropped.
- R10: A cycle with neither a load nor a one-second pulse leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-second advance enable, one cycle per second |
| mode24 | input | 1 | 1 selects 24-hour counting, 0 selects 12-hour with PM flag |
| loadEn | input | 1 | Host register load strobe |
| loadAddr | input | 4 | Register address for the load |
| loadData | input | 8 | Byte to load |
| secOut | output | 8 | BCD seconds |
| minOut | output | 8 | BCD minutes |
| hourOut | output | 8 | BCD hour, bit 5 PM in 12-hour mode |
| wdayOut | output | 8 | Weekday 0 to 6 |
| dayOut | output | 8 | BCD day of month |
| monOut | output | 8 | BCD month in bits 4:0, century flag in bit 7 |
| yearOut | output | 8 | BCD year 00 to 99 |
| oscStop | output | 1 | Oscillator-stop flag; counting frozen while set |

## Verification
The assertions assume the host loads only valid packed-BCD values that suit the current hour mode. They also assume that mode24 changes only together with a reload of the hour, because the stored hour byte is never converted between forms. The stimulus respects this. It switches to 12-hour form only while loading a matching hour byte. It places the clock near each carry boundary by loading 23:59:59 or 11:59:59, so that one or a few pulses cross into the next day, month, year or half-day. The bench model keeps the hour as a 0 to 23 integer and encodes it for whichever mode is active.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_MIN  = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_HOUR = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_WDAY = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_DAY  = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_MON  = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_YEAR = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_STOP = 4'd7;

  localparam int STOP_BIT = 4;
  localparam int PM_BIT   = 5;
  localparam int CENT_BIT = 7;
  localparam logic [REG_W-1:0] LAST_WDAY = 8'd6;

  // Advance strobes from control to datapath
  typedef struct packed {
    logic sec;
    logic min;
    logic hour;
    logic day;
    logic mon;
    logic year;
  } rtcStep_t;

  // Fields sitting at their wrap value, reported by the datapath
  typedef struct packed {
    logic secTop;
    logic minTop;
    logic hourTop;
    logic dayTop;
    logic monTop;
    logic yearTop;
  } rtcTop_t;

  function automatic logic [REG_W-1:0] bcdInc(input logic [REG_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import bcd_rtc_pkg::*;
(
  input  logic [4:0]       monBcd,
  input  logic [REG_W-1:0] yearBcd,
  output logic [REG_W-1:0] lastDay
);
  logic leapYear;
  logic [3:0] ones;

  assign ones = yearBcd[3:0];

  // Two-digit BCD year divisible by 4: tens parity selects the units set
  always_comb begin
    if (yearBcd[4]) leapYear = (ones == 4'd2) || (ones == 4'd6);
    else            leapYear = (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
  end

  always_comb begin
    unique case (monBcd)
      5'h02:                      lastDay = leapYear ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: lastDay = 8'h30;
      default:                    lastDay = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import bcd_rtc_pkg::*;
(
  input  logic     tickEn,
  input  logic     loadEn,
  input  logic     oscStop,
  input  rtcTop_t  fieldTop,
  output rtcStep_t step
);
  logic advance;

  // A load in the same cycle wins; a stopped oscillator freezes the chain
  assign advance = tickEn && !loadEn && !oscStop;

  always_comb begin
    step.sec  = advance;
    step.min  = step.sec  && fieldTop.secTop;
    step.hour = step.min  && fieldTop.minTop;
    step.day  = step.hour && fieldTop.hourTop;
    step.mon  = step.day  && fieldTop.dayTop;
    step.year = step.mon  && fieldTop.monTop;
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import bcd_rtc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          mode24,
  input  logic          loadEn,
  input  logic [AW-1:0] loadAddr,
  input  logic [DW-1:0] loadData,
  input  rtcStep_t      step,
  output rtcTop_t       fieldTop,
  output logic [DW-1:0] secReg,
  output logic [DW-1:0] minReg,
  output logic [DW-1:0] hourReg,
  output logic [DW-1:0] wdayReg,
  output logic [DW-1:0] dayReg,
  output logic [DW-1:0] monReg,
  output logic [DW-1:0] yearReg,
  output logic          stopFlag
);
  logic [DW-1:0] lastDay;
  logic [DW-1:0] hourNext;
  logic [DW-1:0] monNext;
  logic [DW-1:0] lowInc;
  logic [DW-1:0] monInc;
  logic [4:0]    hourLow;
  logic          pmFlag;

  rtc_month_len u_monthLen (
    .monBcd (monReg[4:0]),
    .yearBcd(yearReg),
    .lastDay(lastDay)
  );

  assign hourLow = hourReg[4:0];
  assign pmFlag  = hourReg[PM_BIT];
  assign lowInc  = bcdInc({3'b000, hourLow});
  assign monInc  = bcdInc({3'b000, monReg[4:0]});

  // Hour successor and wrap detect for both hour forms
  always_comb begin
    if (mode24) begin
      fieldTop.hourTop = (hourReg[5:0] == 6'h23);
      hourNext = fieldTop.hourTop ? 8'h00 : bcdInc({2'b00, hourReg[5:0]});
    end else begin
      fieldTop.hourTop = pmFlag && (hourLow == 5'h11);
      if (hourLow == 5'h12)      hourNext = {2'b00, pmFlag, 5'h01};
      else if (hourLow == 5'h11) hourNext = {2'b00, !pmFlag, 5'h12};
      else                       hourNext = {2'b00, pmFlag, lowInc[4:0]};
    end
  end

  assign fieldTop.secTop  = (secReg == 8'h59);
  assign fieldTop.minTop  = (minReg == 8'h59);
  assign fieldTop.dayTop  = (dayReg == lastDay);
  assign fieldTop.monTop  = (monReg[4:0] == 5'h12);
  assign fieldTop.yearTop = (yearReg == 8'h99);

  // Month successor carries the century toggle of a year wrap
  always_comb begin
    monNext = monReg;
    if (step.mon) monNext[4:0] = fieldTop.monTop ? 5'h01 : monInc[4:0];
    if (step.year && fieldTop.yearTop) monNext[CENT_BIT] = !monReg[CENT_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secReg   <= 8'h00;
      minReg   <= 8'h00;
      hourReg  <= 8'h12;
      wdayReg  <= 8'h00;
      dayReg   <= 8'h01;
      monReg   <= 8'h01;
      yearReg  <= 8'h00;
      stopFlag <= 1'b1;
    end else if (loadEn) begin
      unique case (loadAddr)
        ADDR_SEC:  secReg   <= loadData;
        ADDR_MIN:  minReg   <= loadData;
        ADDR_HOUR: hourReg  <= loadData;
        ADDR_WDAY: wdayReg  <= loadData;
        ADDR_DAY:  dayReg   <= loadData;
        ADDR_MON:  monReg   <= loadData;
        ADDR_YEAR: yearReg  <= loadData;
        ADDR_STOP: stopFlag <= loadData[STOP_BIT];
        default: ;
      endcase
    end else begin
      if (step.sec)  secReg  <= fieldTop.secTop ? 8'h00 : bcdInc(secReg);
      if (step.min)  minReg  <= fieldTop.minTop ? 8'h00 : bcdInc(minReg);
      if (step.hour) hourReg <= hourNext;
      if (step.day) begin
        dayReg  <= fieldTop.dayTop ? 8'h01 : bcdInc(dayReg);
        wdayReg <= (wdayReg >= LAST_WDAY) ? 8'h00 : wdayReg + 8'd1;
      end
      if (step.mon)  monReg  <= monNext;
      if (step.year) yearReg <= fieldTop.yearTop ? 8'h00 : bcdInc(yearReg);
    end
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              mode24,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [REG_W-1:0]  loadData,
  output logic [REG_W-1:0]  secOut,
  output logic [REG_W-1:0]  minOut,
  output logic [REG_W-1:0]  hourOut,
  output logic [REG_W-1:0]  wdayOut,
  output logic [REG_W-1:0]  dayOut,
  output logic [REG_W-1:0]  monOut,
  output logic [REG_W-1:0]  yearOut,
  output logic              oscStop
);
  rtcStep_t step;
  rtcTop_t  fieldTop;

  rtc_ctrl u_ctrl (
    .tickEn  (tickEn),
    .loadEn  (loadEn),
    .oscStop (oscStop),
    .fieldTop(fieldTop),
    .step    (step)
  );

  rtc_datapath #(.AW(ADDR_W), .DW(REG_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .mode24  (mode24),
    .loadEn  (loadEn),
    .loadAddr(loadAddr),
    .loadData(loadData),
    .step    (step),
    .fieldTop(fieldTop),
    .secReg  (secOut),
    .minReg  (minOut),
    .hourReg (hourOut),
    .wdayReg (wdayOut),
    .dayReg  (dayOut),
    .monReg  (monOut),
    .yearReg (yearOut),
    .stopFlag(oscStop)
  );
endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       mode24,
  input logic       loadEn,
  input logic [7:0] secOut,
  input logic [7:0] minOut,
  input logic [7:0] hourOut,
  input logic [7:0] wdayOut,
  input logic [7:0] dayOut,
  input logic [7:0] monOut,
  input logic [7:0] yearOut,
  input logic       oscStop
);
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (oscStop && !loadEn) |=> $stable(secOut) && $stable(minOut) && $stable(hourOut) && $stable(dayOut)); // R2

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !loadEn && !oscStop && secOut == 8'h59) |=> (secOut == 8'h00)); // R3

  AST_PM_TOGGLE_AT_TWELVE: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !mode24) |=> (hourOut[5] == $past(hourOut[5])) || (hourOut[4:0] == 5'h12)); // R5

  AST_CENTURY_ON_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> (monOut[7] == $past(monOut[7])) || ($past(yearOut) == 8'h99 && yearOut == 8'h00)); // R7

  AST_WDAY_WITH_DAY: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> (wdayOut == $past(wdayOut)) || (dayOut != $past(dayOut))); // R8

  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && wdayOut < 8'd7) |=> (wdayOut < 8'd7)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !loadEn) |=> $stable(secOut) && $stable(minOut) && $stable(hourOut) && $stable(wdayOut)
      && $stable(dayOut) && $stable(monOut) && $stable(yearOut) && $stable(oscStop)); // R10
endmodule

bind bcd_rtc_core bcd_rtc_checker u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .mode24(mode24), .loadEn(loadEn),
  .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .wdayOut(wdayOut),
  .dayOut(dayOut), .monOut(monOut), .yearOut(yearOut), .oscStop(oscStop)
);

// File: tb/bcd_rtc_core_bench.sv
module bcd_rtc_core_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       mode24 = 1'b1;
  logic       loadEn = 1'b0;
  logic [3:0] loadAddr = 4'd0;
  logic [7:0] loadData = 8'd0;
  logic [7:0] secOut, minOut, hourOut, wdayOut, dayOut, monOut, yearOut;
  logic       oscStop;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curReq = "R1";

  // Behavioural reference state
  int mSec, mMin, mHour, mWday, mDay, mMon, mYear;
  bit mCent, mStop;

  always #5 clk = ~clk;

  bcd_rtc_core u_bcd_rtc_core (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .mode24(mode24), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadData(loadData), .secOut(secOut), .minOut(minOut),
    .hourOut(hourOut), .wdayOut(wdayOut), .dayOut(dayOut), .monOut(monOut),
    .yearOut(yearOut), .oscStop(oscStop)
  );

  function automatic int fromBcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] toBcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] hourByte(input int h, input bit m24);
    if (m24) return toBcd(h);
    return (h >= 12 ? 8'h20 : 8'h00) | toBcd((h + 11) % 12 + 1);
  endfunction

  function automatic int monthDays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic modelReset();
    mSec = 0; mMin = 0; mWday = 0; mDay = 1; mMon = 1; mYear = 0;
    mCent = 0; mStop = 1;
    mHour = mode24 ? 12 : 0;
  endtask

  task automatic modelLoad(input logic [3:0] a, input logic [7:0] d);
    case (a)
      4'd0: mSec = fromBcd(d);
      4'd1: mMin = fromBcd(d);
      4'd2: if (mode24) mHour = fromBcd(d & 8'h3f);
            else mHour = fromBcd(d & 8'h1f) % 12 + (d[5] ? 12 : 0);
      4'd3: mWday = int'(d);
      4'd4: mDay = fromBcd(d);
      4'd5: begin mMon = fromBcd(d & 8'h1f); mCent = d[7]; end
      4'd6: mYear = fromBcd(d);
      4'd7: mStop = d[4];
      default: ;
    endcase
  endtask

  task automatic modelTick();
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHour++;
        if (mHour == 24) begin
          mHour = 0;
          mWday = (mWday + 1) % 7;
          mDay++;
          if (mDay > monthDays(mMon, mYear)) begin
            mDay = 1; mMon++;
            if (mMon == 13) begin
              mMon = 1; mYear++;
              if (mYear == 100) begin mYear = 0; mCent = !mCent; end
            end
          end
        end
      end
    end
  endtask

  task automatic cmp(input string name, input logic [7:0] act, input logic [7:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, name, act, exp);
    end
  endtask

  task automatic compareAll();
    checks++;
    cmp("sec", secOut, toBcd(mSec));
    cmp("min", minOut, toBcd(mMin));
    cmp("hour", hourOut, hourByte(mHour, mode24));
    cmp("wday", wdayOut, 8'(mWday));
    cmp("day", dayOut, toBcd(mDay));
    cmp("mon", monOut, {mCent, 2'b00, 5'(toBcd(mMon))});
    cmp("year", yearOut, toBcd(mYear));
    cmp("stop", {7'd0, oscStop}, {7'd0, mStop});
  endtask

  // One clock: drive, take the edge, update the model, compare away from the edge
  task automatic doCycle(input bit t, input bit l, input logic [3:0] a, input logic [7:0] d);
    tickEn = t; loadEn = l; loadAddr = a; loadData = d;
    @(posedge clk);
    #1;
    if (l) modelLoad(a, d);
    else if (t && !mStop) modelTick();
    compareAll();
  endtask

  task automatic loadReg(input logic [3:0] a, input logic [7:0] d);
    doCycle(0, 1, a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) doCycle(1, 0, 4'd0, 8'd0);
  endtask

  task automatic setTime(input logic [7:0] h, input logic [7:0] dd,
                         input logic [7:0] mo, input logic [7:0] yy);
    loadReg(4'd0, 8'h59);
    loadReg(4'd1, 8'h59);
    loadReg(4'd2, h);
    loadReg(4'd4, dd);
    loadReg(4'd5, mo);
    loadReg(4'd6, yy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    modelReset();
    curReq = "R1";
    compareAll();

    curReq = "R2";   // stopped after reset: pulses are ignored
    ticks(5);
    loadReg(4'd7, 8'h00);
    ticks(3);
    loadReg(4'd7, 8'h10);
    ticks(3);
    loadReg(4'd7, 8'h00);

    curReq = "R10";  // idle cycles
    for (int i = 0; i < 4; i++) doCycle(0, 0, 4'd0, 8'd0);

    curReq = "R9";   // load wins over a same-cycle pulse
    doCycle(1, 1, 4'd0, 8'h30);
    doCycle(1, 1, 4'd3, 8'h06);
    ticks(2);

    curReq = "R3";   // sec/min/hour/day/month/year chain, 24-hour form
    loadReg(4'd0, 8'h50);
    loadReg(4'd1, 8'h59);
    loadReg(4'd2, 8'h23);
    loadReg(4'd4, 8'h31);
    loadReg(4'd5, 8'h12);
    loadReg(4'd6, 8'h99);
    curReq = "R4";
    ticks(15);
    curReq = "R7";   // century now set; wrap again to clear it
    setTime(8'h23, 8'h31, 8'h92, 8'h99);
    ticks(2);
    curReq = "R8";
    for (int i = 0; i < 8; i++) begin
      setTime(8'h23, 8'h10, 8'h03, 8'h21);
      ticks(1);
    end

    curReq = "R6";   // month lengths and leap years
    setTime(8'h23, 8'h28, 8'h02, 8'h24); ticks(1);
    setTime(8'h23, 8'h29, 8'h02, 8'h24); ticks(1);
    setTime(8'h23, 8'h28, 8'h02, 8'h23); ticks(1);
    setTime(8'h23, 8'h28, 8'h02, 8'h00); ticks(1);
    setTime(8'h23, 8'h28, 8'h02, 8'h18); ticks(1);
    setTime(8'h23, 8'h30, 8'h04, 8'h10); ticks(1);
    setTime(8'h23, 8'h30, 8'h11, 8'h10); ticks(1);
    setTime(8'h23, 8'h30, 8'h01, 8'h10); ticks(1);
    setTime(8'h23, 8'h31, 8'h01, 8'h10); ticks(1);
    setTime(8'h23, 8'h31, 8'h07, 8'h10); ticks(1);

    curReq = "R5";   // 12-hour form: hour reloaded as the mode changes
    mode24 = 1'b0;
    loadReg(4'd2, 8'h11);
    setTime(8'h11, 8'h15, 8'h06, 8'h30); ticks(2);
    setTime(8'h32, 8'h15, 8'h06, 8'h30); ticks(2);
    setTime(8'h31, 8'h30, 8'h06, 8'h30); ticks(2);
    setTime(8'h12, 8'h15, 8'h06, 8'h30); ticks(2);
    setTime(8'h09, 8'h15, 8'h06, 8'h30); ticks(2);
    mode24 = 1'b1;
    loadReg(4'd2, 8'h05);
    ticks(3);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule